// File: doc/BRIEF.md
# Synchronous Clock Output Enable Gate

The block builds a divided clock from a fast core clock and sends it to a group of output lanes. Each lane drives a true pin and a complement pin. A lane turns on or off only at a period boundary of the divided clock, so every high pulse it sends has full width. Three things must agree before a lane drives: a shared active-low enable pin, a per-lane software disable bit, and an initialisation-done flag. Any one of them holds the lane quiet.

The divided clock has a period of `2*H` core cycles and is high for the first `H` of them. `H` is taken from `half_div` at each period boundary. The shared enable pin is asynchronous. It is sampled once per divided period through two stages, so the latency from pin to output is a fixed number of output periods. The complement pin either follows the true pin or is its inverse, chosen per lane.

Top module: `oeg_gate_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `out_t` and `out_c` are all 0. After reset every lane is off, the pin history reads as disabling, and the first divided period is 2 cycles long (H = 1).
- R2: The divided level is high for the first H cycles of each 2*H-cycle period. H is `half_div` sampled at the last cycle of the previous period, and a value of 0 counts as 1. An enabled lane's `out_t` copies this level one core cycle later.
- R3: A lane's on/off state changes only at a period boundary. Every high pulse on `out_t` therefore lasts exactly H cycles of its own period and is never cut short.
- R4: `oe_n` is active low. Once it has propagated, a high level turns off every lane, and a low level lets each lane on when its other conditions allow.
- R5: `oe_n` is captured at the last cycle of each period into a two-entry history. A lane's state at a boundary uses the oldest entry, taken before that boundary's shift. After `oe_n` changes, the old state therefore holds for the rest of the current period and for exactly two more full periods.
- R6: `reg_dis[i]` = 1 turns off lane i alone from the next period boundary, even while the pin enables it. Other lanes are unaffected.
- R7: While `init_done` is 0 at a period boundary, all lanes are off for the next period.
- R8: `out_c[i]` = `out_t[i]` XOR `pol_inv[i]`, registered in the same cycle as `out_t`. With `pol_inv[i]` = 0 the complement is in phase. With 1 it is inverted, so a disabled lane holds `out_c` high.
- R9: A disabled lane holds `out_t` static low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that the divided clock is built from |
| rst | input | 1 | Synchronous active-high reset |
| half_div | input | HALF_W | Half-period H in core cycles (0 treated as 1) |
| init_done | input | 1 | High once initialisation is complete; low squelches all lanes |
| oe_n | input | 1 | Shared asynchronous output-enable pin, active low |
| reg_dis | input | NUM_OUT | Per-lane software disable, 1 = off |
| pol_inv | input | NUM_OUT | Per-lane complement polarity, 1 = inverted |
| out_t | output | NUM_OUT | Gated true clock per lane |
| out_c | output | NUM_OUT | Gated complement clock per lane |

## Verification
The following are checked by assertions on every cycle:
- the lane state never changes while the true output is high;
- each off condition (pin, software bit, missing init) forces the lane off after the boundary;
- the pin history and the divided level move only at boundaries;
- the true output never rises without the divided level behind it.

Other behaviour shows only in the bench's scenarios, which compare against a reference model on every clock:
- the exact number of periods that pass between a pin change and the output change;
- full pulse width across a change of `half_div`;
- squelch release after init;
- the complement polarity.

// File: rtl/oeg_pkg.sv
package oeg_pkg;

    // Two-entry history of the sampled enable pin (1 = pin disabling)
    typedef struct packed {
        logic older;
        logic newer;
    } pin_hist_t;

    // Per-lane registered state
    typedef struct packed {
        logic gate;
        logic t;
        logic c;
    } lane_st_t;

    localparam pin_hist_t PIN_HIST_RESET = '{older: 1'b1, newer: 1'b1};
    localparam lane_st_t  LANE_RESET     = '{gate: 1'b0, t: 1'b0, c: 1'b0};

    // A lane may drive only when every condition permits it
    function automatic logic lane_permit(input logic init_ok,
                                         input logic pin_off,
                                         input logic sw_off);
        return init_ok & ~pin_off & ~sw_off;
    endfunction

endpackage

// File: rtl/oeg_divider.sv
module oeg_divider #(
    parameter int HALF_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HALF_W-1:0] half_div,
    output logic              tick,
    output logic              level
);
    localparam int CW = HALF_W + 1;

    logic [CW-1:0]     cnt_q;
    logic [HALF_W-1:0] half_q;
    logic [HALF_W-1:0] half_eff;
    logic [CW-1:0]     last_cnt;

    assign half_eff = (half_div == '0) ? HALF_W'(1) : half_div;
    assign last_cnt = {half_q, 1'b0} - CW'(1);
    assign tick     = (cnt_q == last_cnt);
    assign level    = (cnt_q < {1'b0, half_q});

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            half_q <= HALF_W'(1);
        end else if (tick) begin
            cnt_q  <= '0;
            half_q <= half_eff;
        end else begin
            cnt_q  <= cnt_q + CW'(1);
        end
    end

    // R2: the divided level only rises at the start of a period
    p_level_rise_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(level) |-> $past(tick));

endmodule

// File: rtl/oeg_pin_sync.sv
module oeg_pin_sync
    import oeg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic pin_n,
    output logic pin_off
);
    pin_hist_t hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= PIN_HIST_RESET;
        end else if (tick) begin
            hist_q.older <= hist_q.newer;
            hist_q.newer <= pin_n;
        end
    end

    assign pin_off = hist_q.older;

    // R5: the synchronised pin value moves only at a period boundary
    p_sync_step_r5: assert property (@(posedge clk) disable iff (rst)
        $changed(pin_off) |-> $past(tick));

endmodule

// File: rtl/oeg_lane.sv
module oeg_lane
    import oeg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic level,
    input  logic init_ok,
    input  logic pin_off,
    input  logic sw_off,
    input  logic pol_inv,
    output logic out_t,
    output logic out_c
);
    lane_st_t st_q;
    logic     drive;

    assign drive = st_q.gate & level;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= LANE_RESET;
        end else begin
            if (tick) begin
                st_q.gate <= lane_permit(init_ok, pin_off, sw_off);
            end
            st_q.t <= drive;
            st_q.c <= drive ^ pol_inv;
        end
    end

    assign out_t = st_q.t;
    assign out_c = st_q.c;

    // R3: the lane switches only while its true output is low
    p_gate_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        $changed(st_q.gate) |-> !out_t);

    // R4: a disabling pin forces the lane off at the boundary
    p_pin_off_r4: assert property (@(posedge clk) disable iff (rst)
        (tick && pin_off) |=> !st_q.gate);

    // R6: the software bit forces the lane off at the boundary
    p_sw_off_r6: assert property (@(posedge clk) disable iff (rst)
        (tick && sw_off) |=> !st_q.gate);

    // R7: missing init squelches the lane at the boundary
    p_squelch_r7: assert property (@(posedge clk) disable iff (rst)
        (tick && !init_ok) |=> !st_q.gate);

    // R9: the true output never rises without the divided level behind it
    p_true_src_r9: assert property (@(posedge clk) disable iff (rst)
        out_t |-> $past(level));

endmodule

// File: rtl/oeg_gate_top.sv
module oeg_gate_top
    import oeg_pkg::*;
#(
    parameter int NUM_OUT = 4,
    parameter int HALF_W  = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [HALF_W-1:0]  half_div,
    input  logic               init_done,
    input  logic               oe_n,
    input  logic [NUM_OUT-1:0] reg_dis,
    input  logic [NUM_OUT-1:0] pol_inv,
    output logic [NUM_OUT-1:0] out_t,
    output logic [NUM_OUT-1:0] out_c
);
    logic tick;
    logic level;
    logic pin_off;

    oeg_divider #(.HALF_W(HALF_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .half_div (half_div),
        .tick     (tick),
        .level    (level)
    );

    oeg_pin_sync u_sync (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .pin_n   (oe_n),
        .pin_off (pin_off)
    );

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_lane
        oeg_lane u_lane (
            .clk     (clk),
            .rst     (rst),
            .tick    (tick),
            .level   (level),
            .init_ok (init_done),
            .pin_off (pin_off),
            .sw_off  (reg_dis[i]),
            .pol_inv (pol_inv[i]),
            .out_t   (out_t[i]),
            .out_c   (out_c[i])
        );
    end

endmodule

// File: tb/tb_oeg_gate_top.sv
module tb_oeg_gate_top;
    localparam int N  = 4;
    localparam int HW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [HW-1:0] half_div = HW'(3);
    logic          init_done = 1'b0;
    logic          oe_n = 1'b0;
    logic [N-1:0]  reg_dis = '0;
    logic [N-1:0]  pol_inv = '0;
    logic [N-1:0]  out_t, out_c;

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    oeg_gate_top #(.NUM_OUT(N), .HALF_W(HW)) dut (
        .clk(clk), .rst(rst), .half_div(half_div), .init_done(init_done),
        .oe_n(oe_n), .reg_dis(reg_dis), .pol_inv(pol_inv),
        .out_t(out_t), .out_c(out_c)
    );

    // Behavioural reference model
    int       m_pos, m_half;
    bit       m_hist[$];
    bit [N-1:0] m_on, m_t, m_c;

    always @(posedge clk) begin
        if (rst) begin
            m_pos = 0; m_half = 1;
            m_hist = '{1'b1, 1'b1};
            m_on = '0; m_t = '0; m_c = '0;
        end else begin
            bit hi, boundary;
            hi       = (m_pos < m_half);
            boundary = (m_pos == 2 * m_half - 1);
            for (int i = 0; i < N; i++) begin
                m_t[i] = m_on[i] & hi;
                m_c[i] = (m_on[i] & hi) ^ pol_inv[i];
            end
            if (boundary) begin
                for (int i = 0; i < N; i++)
                    m_on[i] = init_done && !m_hist[0] && !reg_dis[i];
                void'(m_hist.pop_front());
                m_hist.push_back(oe_n);
                m_pos  = 0;
                m_half = (half_div == 0) ? 1 : int'(half_div);
            end else begin
                m_pos++;
            end
        end
    end

    // Per-clock comparison and pulse width monitor
    int run_len[N];
    int run_exp[N];
    bit seen_rst = 1'b0;

    always @(negedge clk) begin
        if (rst) begin
            seen_rst = 1'b1;
            for (int i = 0; i < N; i++) begin run_len[i] = 0; run_exp[i] = 0; end
        end else if (seen_rst) begin
            for (int i = 0; i < N; i++) begin
                n_chk++;
                if (out_t[i] !== m_t[i] || out_c[i] !== m_c[i]) begin
                    n_bad++;
                    $display("FAIL %s lane %0d: t/c=%b%b expected %b%b at %0t",
                             cur_req, i, out_t[i], out_c[i], m_t[i], m_c[i], $time);
                end
                if (out_t[i] === 1'b1) begin
                    if (run_len[i] == 0) run_exp[i] = m_half;
                    run_len[i]++;
                end else if (run_len[i] != 0) begin
                    n_chk++;
                    if (run_len[i] != run_exp[i]) begin
                        n_bad++;
                        $display("FAIL R3 lane %0d pulse width %0d expected %0d",
                                 i, run_len[i], run_exp[i]);
                    end
                    run_len[i] = 0;
                end
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic count_rises(input int lane, input int cycles, output int rises);
        logic prev;
        rises = 0;
        prev  = out_t[lane];
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (out_t[lane] && !prev) rises++;
            prev = out_t[lane];
        end
    endtask

    task automatic run(input int cycles);
        repeat (cycles) @(negedge clk);
    endtask

    initial begin
        repeat (10000) @(posedge clk);
        n_bad++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int r;
        // R1: reset state
        repeat (4) @(negedge clk);
        check("R1 out_t in reset", int'(out_t), 0);
        check("R1 out_c in reset", int'(out_c), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 out_t after reset", int'(out_t), 0);

        // R7: squelched while init not done
        cur_req = "R7";
        count_rises(0, 40, r);
        check("R7 no pulses before init", r, 0);

        // R2/R4: release init, pin enabled
        cur_req = "R2";
        init_done = 1'b1;
        run(60);
        count_rises(0, 24, r);
        check("R2 pulses at H=3 in 24 cycles", r, 4);

        // R3: change half period mid-run
        cur_req = "R3";
        half_div = HW'(5);
        run(70);

        // R6: software disable one lane
        cur_req = "R6";
        reg_dis = 4'b0010;
        run(30);
        check("R6 lane1 held low", int'(out_t[1]), 0);
        count_rises(1, 30, r);
        check("R6 lane1 no pulses", r, 0);
        reg_dis = '0;
        run(40);

        // R8: complement polarity
        cur_req = "R8";
        pol_inv = 4'b1100;
        run(50);

        // R5: pin latency, raised in the middle of a high pulse
        cur_req = "R5";
        half_div = HW'(4);
        run(20);
        @(negedge clk); while (out_t[0] !== 1'b1) @(negedge clk);
        @(negedge clk);
        oe_n = 1'b1;
        count_rises(0, 80, r);
        check("R5 further pulses after pin off", r, 2);
        check("R4 lane0 low with pin off", int'(out_t[0]), 0);
        check("R8 inverted complement held high", int'(out_c[2]), 1);

        // R4: re-enable via pin, then H = 0 treated as 1
        cur_req = "R4";
        oe_n = 1'b0;
        run(60);
        cur_req = "R2";
        half_div = '0;
        run(30);
        count_rises(3, 20, r);
        check("R2 H=0 runs at H=1", r, 10);

        // R7: squelch again
        cur_req = "R7";
        half_div = HW'(2);
        init_done = 1'b0;
        run(20);
        count_rises(0, 30, r);
        check("R7 squelched after init drop", r, 0);
        cur_req = "R9";
        check("R9 disabled true output low", int'(out_t), 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule